// File: doc/BRIEF.md
# Fault-Tolerant Layered Mesh Route Selector

This block is the route-decision stage of a seven-port router in a three-dimensional mesh network-on-chip. A header flit supplies a destination (X, Y, Z). The router supplies its own position. The block returns one output port as a one-hot vector. If the packet is already in its destination layer, it is steered Y first and then X toward the destination. If the packet must change layer, it does not use the vertical port of the current router. It first travels inside its own layer to a stored rally node for the needed direction: one node for climbing and one for descending. Each rally node is a router whose vertical link in that direction works. At the rally node the packet leaves through UP or DOWN.

The two rally coordinate pairs sit in small registers. They are loaded through a plain configuration port that models one-time-programmable storage. After reset both pairs equal the router's own X/Y, which gives ordinary layer-first routing on a fault-free router. A sticky lock freezes the pairs until the next reset.

The header path is a valid/ready stream with no storage. The route output is combinational. `rt_valid` follows `hdr_valid`, and `hdr_ready` follows `rt_ready` in the same cycle. A stalled downstream therefore stalls the header source directly. The header must stay stable while `hdr_valid` is high and `hdr_ready` is low.

Top module: `ft3d_route_unit`

## Requirements
- R1: While `hdr_valid` is high, `rt_port` has exactly one bit set. While it is low, `rt_port` is all zeros. Bit positions are: 0 LOCAL, 1 NORTH, 2 SOUTH, 3 EAST, 4 WEST, 5 UP, 6 DOWN.
- R2: When `here_z == dst_z`, Y is resolved first. `here_y > dst_y` selects EAST (bit 3), and `here_y < dst_y` selects WEST (bit 4). UP and DOWN are never chosen in this case.
- R3: When `here_z == dst_z` and `here_y == dst_y`: `here_x > dst_x` selects NORTH (bit 1), `here_x < dst_x` selects SOUTH (bit 2), and equality selects LOCAL (bit 0).
- R4: When `here_z > dst_z`, the target is the stored descend pair. If the router's X and Y equal that pair, the output is DOWN (bit 6). Otherwise the Y-then-X rules of R2/R3 steer toward the pair. LOCAL and UP are never chosen.
- R5: When `here_z < dst_z`, the target is the stored climb pair. If the router's X and Y equal that pair, the output is UP (bit 5). Otherwise the Y-then-X rules steer toward the pair. LOCAL and DOWN are never chosen.
- R6: A synchronous reset (active-low `rst_n`, sampled on a rising edge) loads both pairs with `here_x`/`here_y` and clears the lock.
- R7: With `cfg_we` high and the lock clear, the rising edge stores `cfg_x`/`cfg_y` into the climb pair when `cfg_sel` is 0, or into the descend pair when `cfg_sel` is 1. Routing uses the new pair from the next cycle on.
- R8: `cfg_lock` high on a rising edge sets the lock. A write in that same cycle is still accepted. While the lock is set, writes leave both pairs unchanged. Only reset clears the lock.
- R9: `rt_valid` equals `hdr_valid`, and `hdr_ready` equals `rt_ready`, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| here_x | input | XW | Router's own X |
| here_y | input | YW | Router's own Y |
| here_z | input | ZW | Router's own layer |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header accepted (follows rt_ready) |
| dst_x | input | XW | Destination X |
| dst_y | input | YW | Destination Y |
| dst_z | input | ZW | Destination layer |
| rt_valid | output | 1 | Route decision valid |
| rt_ready | input | 1 | Downstream can take the decision |
| rt_port | output | 7 | One-hot chosen port |
| cfg_we | input | 1 | Rally pair write enable |
| cfg_sel | input | 1 | 0 climb pair, 1 descend pair |
| cfg_x | input | XW | X to store |
| cfg_y | input | YW | Y to store |
| cfg_lock | input | 1 | Set the sticky write lock |

## Verification
A configuration write and a route decision can fall in the same cycle. The bench provokes this by holding a header that needs a layer change while it writes the matching rally pair. The decision in that cycle must still follow the old pair, and the decision one edge later must follow the new one; both are compared with a reference model.

The lock and a write can also coincide. The bench asserts `cfg_lock` and `cfg_we` together and expects that write to land. It then expects every later write to be dropped, which it observes through the route chosen for layer-changing headers.

// File: rtl/ft3d_pkg.sv
package ft3d_pkg;
  localparam int NPORT = 7;
  typedef enum logic [2:0] {
    P_LOCAL = 3'd0,
    P_NORTH = 3'd1,
    P_SOUTH = 3'd2,
    P_EAST  = 3'd3,
    P_WEST  = 3'd4,
    P_UP    = 3'd5,
    P_DOWN  = 3'd6
  } port_e;
  // index of the in-layer target feeding the final choice
  localparam int TGT_DEST = 0;
  localparam int TGT_UP   = 1;
  localparam int TGT_DOWN = 2;
  localparam int NTGT     = 3;
endpackage

// File: rtl/ft3d_rally_regs.sv
module ft3d_rally_regs #(
  parameter int XW = 2,
  parameter int YW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] own_x,
  input  logic [YW-1:0] own_y,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [XW-1:0] wr_x,
  input  logic [YW-1:0] wr_y,
  input  logic          lock_set,
  output logic [XW-1:0] up_x,
  output logic [YW-1:0] up_y,
  output logic [XW-1:0] dn_x,
  output logic [YW-1:0] dn_y,
  output logic          locked
);
  logic wr_ok;
  assign wr_ok = wr_en && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_x   <= own_x;
      up_y   <= own_y;
      dn_x   <= own_x;
      dn_y   <= own_y;
      locked <= 1'b0;
    end else begin
      if (lock_set) locked <= 1'b1;
      if (wr_ok && !wr_sel) begin
        up_x <= wr_x;
        up_y <= wr_y;
      end
      if (wr_ok && wr_sel) begin
        dn_x <= wr_x;
        dn_y <= wr_y;
      end
    end
  end
endmodule

// File: rtl/ft3d_plane_steer.sv
module ft3d_plane_steer
  import ft3d_pkg::*;
#(
  parameter int    XW     = 2,
  parameter int    YW     = 2,
  parameter port_e ARRIVE = P_LOCAL
) (
  input  logic [XW-1:0] at_x,
  input  logic [YW-1:0] at_y,
  input  logic [XW-1:0] goal_x,
  input  logic [YW-1:0] goal_y,
  output port_e         dir
);
  always_comb begin
    if (at_y > goal_y)      dir = P_EAST;
    else if (at_y < goal_y) dir = P_WEST;
    else if (at_x > goal_x) dir = P_NORTH;
    else if (at_x < goal_x) dir = P_SOUTH;
    else                    dir = ARRIVE;
  end
endmodule

// File: rtl/ft3d_route_unit.sv
module ft3d_route_unit
  import ft3d_pkg::*;
#(
  parameter int XW = 2,
  parameter int YW = 2,
  parameter int ZW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] here_x,
  input  logic [YW-1:0] here_y,
  input  logic [ZW-1:0] here_z,
  input  logic          hdr_valid,
  output logic          hdr_ready,
  input  logic [XW-1:0] dst_x,
  input  logic [YW-1:0] dst_y,
  input  logic [ZW-1:0] dst_z,
  output logic          rt_valid,
  input  logic          rt_ready,
  output logic [6:0]    rt_port,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [XW-1:0] cfg_x,
  input  logic [YW-1:0] cfg_y,
  input  logic          cfg_lock
);
  logic [XW-1:0] up_x_q, dn_x_q;
  logic [YW-1:0] up_y_q, dn_y_q;
  logic          lock_q;

  ft3d_rally_regs #(.XW(XW), .YW(YW)) u_regs (
    .clk(clk), .rst_n(rst_n), .own_x(here_x), .own_y(here_y),
    .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_x(cfg_x), .wr_y(cfg_y),
    .lock_set(cfg_lock),
    .up_x(up_x_q), .up_y(up_y_q), .dn_x(dn_x_q), .dn_y(dn_y_q),
    .locked(lock_q)
  );

  logic [XW-1:0] goal_x [NTGT];
  logic [YW-1:0] goal_y [NTGT];
  port_e         cand   [NTGT];

  assign goal_x[TGT_DEST] = dst_x;
  assign goal_y[TGT_DEST] = dst_y;
  assign goal_x[TGT_UP]   = up_x_q;
  assign goal_y[TGT_UP]   = up_y_q;
  assign goal_x[TGT_DOWN] = dn_x_q;
  assign goal_y[TGT_DOWN] = dn_y_q;

  for (genvar g = 0; g < NTGT; g++) begin : g_steer
    localparam port_e ARR = (g == TGT_UP)   ? P_UP   :
                            (g == TGT_DOWN) ? P_DOWN : P_LOCAL;
    ft3d_plane_steer #(.XW(XW), .YW(YW), .ARRIVE(ARR)) u_steer (
      .at_x(here_x), .at_y(here_y),
      .goal_x(goal_x[g]), .goal_y(goal_y[g]),
      .dir(cand[g])
    );
  end

  port_e pick;
  always_comb begin
    if (here_z == dst_z)     pick = cand[TGT_DEST];
    else if (here_z > dst_z) pick = cand[TGT_DOWN];
    else                     pick = cand[TGT_UP];
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_onehot
    assign rt_port[p] = hdr_valid && (pick == port_e'(p));
  end

  assign rt_valid  = hdr_valid;
  assign hdr_ready = rt_ready;
endmodule

// File: rtl/ft3d_route_chk.sv
module ft3d_route_chk #(
  parameter int XW = 2,
  parameter int YW = 2,
  parameter int ZW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hdr_valid,
  input logic [ZW-1:0] here_z,
  input logic [ZW-1:0] dst_z,
  input logic [6:0]    rt_port,
  input logic          cfg_we,
  input logic          cfg_sel,
  input logic [XW-1:0] cfg_x,
  input logic [YW-1:0] cfg_y,
  input logic          lock_q,
  input logic [XW-1:0] up_x,
  input logic [YW-1:0] up_y,
  input logic [XW-1:0] dn_x,
  input logic [YW-1:0] dn_y
);
  AST_ONEHOT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> $countones(rt_port) == 1); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |-> rt_port == 7'd0); // R1
  AST_FLAT_NO_VERT: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && here_z == dst_z) |-> (!rt_port[5] && !rt_port[6])); // R2
  AST_FALL_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && here_z > dst_z) |-> (!rt_port[0] && !rt_port[5])); // R4
  AST_RISE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && here_z < dst_z) |-> (!rt_port[0] && !rt_port[6])); // R5
  AST_WR_CLIMB: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !lock_q && !cfg_sel) |=> (up_x == $past(cfg_x) && up_y == $past(cfg_y))); // R7
  AST_WR_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !lock_q && cfg_sel) |=> (dn_x == $past(cfg_x) && dn_y == $past(cfg_y))); // R7
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(up_x) && $stable(up_y) && $stable(dn_x) && $stable(dn_y))); // R8
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R8
endmodule

bind ft3d_route_unit ft3d_route_chk #(.XW(XW), .YW(YW), .ZW(ZW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .here_z(here_z),
  .dst_z(dst_z), .rt_port(rt_port), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .cfg_x(cfg_x), .cfg_y(cfg_y), .lock_q(lock_q),
  .up_x(up_x_q), .up_y(up_y_q), .dn_x(dn_x_q), .dn_y(dn_y_q)
);

// File: tb/ft3d_route_unit_bench.sv
module ft3d_route_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] here_x = 2'd2, here_y = 2'd1, here_z = 2'd1;
  logic       hdr_valid = 1'b0, rt_ready = 1'b1;
  logic [1:0] dst_x = '0, dst_y = '0, dst_z = '0;
  logic       hdr_ready, rt_valid;
  logic [6:0] rt_port;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0, cfg_lock = 1'b0;
  logic [1:0] cfg_x = '0, cfg_y = '0;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ft3d_route_unit u_ft3d_route_unit (
    .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y), .here_z(here_z),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .dst_x(dst_x), .dst_y(dst_y),
    .dst_z(dst_z), .rt_valid(rt_valid), .rt_ready(rt_ready), .rt_port(rt_port),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_x(cfg_x), .cfg_y(cfg_y),
    .cfg_lock(cfg_lock)
  );

  localparam logic [6:0] O_L = 7'b0000001, O_N = 7'b0000010, O_S = 7'b0000100,
                         O_E = 7'b0001000, O_W = 7'b0010000, O_U = 7'b0100000,
                         O_D = 7'b1000000;

  // {dst_x, dst_y, dst_z, expected} with the router at (2,1,1), rally pairs at reset
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    {2'd2, 2'd1, 2'd1, O_L},  // R3 equal
    {2'd0, 2'd1, 2'd1, O_N},  // R3 x greater
    {2'd3, 2'd1, 2'd1, O_S},  // R3 x smaller
    {2'd2, 2'd0, 2'd1, O_E},  // R2 y greater
    {2'd2, 2'd3, 2'd1, O_W},  // R2 y smaller
    {2'd0, 2'd0, 2'd1, O_E},  // R2 y before x
    {2'd0, 2'd3, 2'd2, O_U},  // R5 R6 climb at self
    {2'd1, 2'd1, 2'd3, O_U},  // R5 R6
    {2'd3, 2'd0, 2'd0, O_D},  // R4 R6 descend at self
    {2'd2, 2'd1, 2'd0, O_D}   // R4 R6
  };

  logic [1:0] m_up_x, m_up_y, m_dn_x, m_dn_y;

  function automatic logic [6:0] steer(input logic [1:0] ax, ay, gx, gy,
                                        input logic [6:0] arrive);
    if (ay > gy) return O_E;
    if (ay < gy) return O_W;
    if (ax > gx) return O_N;
    if (ax < gx) return O_S;
    return arrive;
  endfunction

  function automatic logic [6:0] model(input logic [1:0] dx, dy, dz);
    if (here_z == dz) return steer(here_x, here_y, dx, dy, O_L);
    if (here_z > dz)  return steer(here_x, here_y, m_dn_x, m_dn_y, O_D);
    return steer(here_x, here_y, m_up_x, m_up_y, O_U);
  endfunction

  task automatic check(input string tag, input logic [6:0] got, exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic hdr(input logic [1:0] dx, dy, dz);
    @(negedge clk);
    hdr_valid = 1'b1; dst_x = dx; dst_y = dy; dst_z = dz;
    #2;
  endtask

  task automatic wr(input logic sel, input logic [1:0] x, y, input logic lk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_x = x; cfg_y = y; cfg_lock = lk;
    @(negedge clk);
    cfg_we = 1'b0; cfg_lock = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; hdr_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_up_x = here_x; m_up_y = here_y; m_dn_x = here_x; m_dn_y = here_y;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    #2;
    check("R1 idle zero after reset", rt_port, 7'd0);
    check("R9 valid low follows", {6'd0, rt_valid}, 7'd0);

    foreach (VEC[i]) begin
      hdr(VEC[i][12:11], VEC[i][10:9], VEC[i][8:7]);
      check($sformatf("R2 R3 R4 R5 R6 vector %0d", i), rt_port, VEC[i][6:0]);
    end

    // R9 handshake passthrough
    @(negedge clk); rt_ready = 1'b0; #2;
    check("R9 ready low", {5'd0, rt_valid, hdr_ready}, 7'b0000010);
    @(negedge clk); rt_ready = 1'b1; #2;
    check("R9 ready high", {5'd0, rt_valid, hdr_ready}, 7'b0000011);

    // R7 write coincident with a layer-changing header
    hdr(2'd0, 2'd0, 2'd3);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 1'b0; cfg_x = 2'd0; cfg_y = 2'd3; #2;
    check("R7 old climb pair in write cycle", rt_port, O_U);
    @(negedge clk); cfg_we = 1'b0; #2;
    check("R7 new climb pair after edge", rt_port, O_W);
    wr(1'b1, 2'd3, 2'd1, 1'b0);
    hdr(2'd0, 2'd0, 2'd0); #0;
    check("R7 descend pair steers south", rt_port, O_S);
    hdr(2'd1, 2'd1, 2'd2);
    check("R7 climb unchanged by descend write", rt_port, O_W);

    // R4 R5 exhaustive comparison with random positions and rally pairs
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      here_x = 2'($urandom()); here_y = 2'($urandom()); here_z = 2'($urandom());
      do_reset();
      m_up_x = 2'($urandom()); m_up_y = 2'($urandom());
      m_dn_x = 2'($urandom()); m_dn_y = 2'($urandom());
      wr(1'b0, m_up_x, m_up_y, 1'b0);
      wr(1'b1, m_dn_x, m_dn_y, 1'b0);
      for (int d = 0; d < 64; d++) begin
        hdr(2'(d), 2'(d >> 2), 2'(d >> 4));
        check($sformatf("R2 R3 R4 R5 sweep t%0d d%0d", t, d), rt_port,
              model(2'(d), 2'(d >> 2), 2'(d >> 4)));
      end
    end

    // R8 lock: write in lock cycle lands, later writes drop
    @(negedge clk);
    here_x = 2'd2; here_y = 2'd1; here_z = 2'd1;
    do_reset();
    wr(1'b0, 2'd2, 2'd3, 1'b1);
    hdr(2'd0, 2'd0, 2'd3);
    check("R8 write with lock accepted", rt_port, O_W);
    wr(1'b0, 2'd2, 2'd1, 1'b0);
    hdr(2'd0, 2'd0, 2'd3);
    check("R8 climb write ignored", rt_port, O_W);
    wr(1'b1, 2'd0, 2'd1, 1'b0);
    hdr(2'd0, 2'd0, 2'd0);
    check("R8 descend write ignored", rt_port, O_D);
    do_reset();
    wr(1'b1, 2'd0, 2'd1, 1'b0);
    hdr(2'd0, 2'd0, 2'd0);
    check("R6 R8 reset clears lock", rt_port, O_N);

    @(negedge clk); hdr_valid = 1'b0; #2;
    check("R1 idle zero", rt_port, 7'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule